// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the message-signalled interrupt vector table and the pending-bit array of one PCI function. It decides, request by request, whether an interrupt becomes an outgoing message write or is parked as pending. Device logic raises per-vector interrupt requests. Software programs each vector's target address, payload and mask through a dword-wide register window into a 4 KB region. A parked vector is replayed as soon as it becomes unmasked, either because its own mask bit is cleared by a table write or because the function-wide mask is lifted by a control write.

Each outgoing message carries a 64-bit address and 32 bits of data over a valid/ready handshake. A control write that leaves message interrupts enabled produces a one-cycle strobe that drops the legacy wired interrupt. When that write also leaves the function unmasked, the block walks the implemented vectors in ascending order, one per cycle, and replays every vector that is pending and unmasked. It raises `busy` until the walk ends. Device logic also keeps a reference count per vector with use and unuse commands. Requests to a vector whose count is zero are discarded.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, every implemented vector reads as masked (control word value 1). Its address and data words read 0, the pending array reads 0, `msg_valid`, `busy` and `intx_deassert` are low, and the enable and function-mask bits are clear.
- R2: Vector v occupies bytes v*16 to v*16+15. Word 0 is the address low half, word 1 the address high half, word 2 the message data and word 3 the control word. Only bit 0 of the control word (the mask) is stored; its other bits read 0.
- R3: An access counts only when `reg_be` is 4'hF. A narrower read returns 0 and a narrower write changes nothing.
- R4: The pending array is read-only at offset 0x800. The dword at 0x800 holds the pending bit of vector v in bit v, which is bit v mod 8 of byte v div 8. Other dwords at 0x800 and above read 0, and writes anywhere at or above 0x800 change nothing.
- R5: A request to an in-use, effectively unmasked vector raises `msg_valid` at the next clock edge. The message has address {high, low} and the entry's data.
- R6: A request to a vector at or beyond `NUM_VEC`, or to a vector whose use count is zero, is discarded. It emits no message and sets no pending bit.
- R7: A vector is effectively masked when its own mask bit or the function mask is set. A request to an in-use, effectively masked vector sets its pending bit and emits nothing.
- R8: After a full-dword table write, the vector owning that entry is checked. If it is now effectively unmasked and pending, its pending bit clears and its message is emitted at the same edge.
- R9: A control write that leaves enable set pulses `intx_deassert` for one cycle. If it also leaves the function mask clear, `busy` rises and the vectors are scanned in ascending order. Each unmasked pending vector is cleared and sent, with one vector examined per cycle in which the output slot is free.
- R10: Use increments a vector's count and unuse decrements it. Unuse at count zero does nothing. A decrement that reaches zero clears that vector's pending bit.
- R11: While `msg_valid` is high and `msg_ready` is low, the message stays valid with its address and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_rd | input | 1 | Register window read strobe |
| reg_addr | input | 12 | Byte offset inside the 4 KB window |
| reg_be | input | 4 | Byte enables; only 4'hF is a legal access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_en | input | 1 | New enable value |
| ctl_maskall | input | 1 | New function mask value |
| irq_req | input | 1 | Interrupt request pulse |
| irq_vec | input | 5 | Vector of the request |
| busy | output | 1 | Requests, table writes and control writes must wait |
| use_cmd | input | 1 | Increment use count of `cmd_vec` |
| unuse_cmd | input | 1 | Decrement use count of `cmd_vec` |
| cmd_vec | input | 5 | Vector for use/unuse |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| intx_deassert | output | 1 | One-cycle legacy interrupt deassert strobe |

## Verification
The checks assume that the environment drives `irq_req`, `reg_wr` and `ctl_wr` only while `busy` is low, and never asserts more than one of them in the same cycle. They also assume that use and unuse are not issued together. The message-hold property depends on this, because a table write during a stall could otherwise change a held address. The directed bench drives each stimulus as a single one-cycle pulse on a falling edge. It waits for `busy` to fall after any scan before it issues the next operation.

// File: rtl/msix_pkg.sv
package msix_pkg;

    // Word position inside one 16-byte vector entry (selected by address bits 3:2)
    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_ADDR_HI = 2'd1,
        W_DATA    = 2'd2,
        W_CTRL    = 2'd3
    } word_sel_e;

    localparam int unsigned MAX_VEC    = 32;
    localparam int unsigned VEC_PORT_W = 5;
    localparam int unsigned PEND_BASE  = 12'h800;

endpackage

// File: rtl/msix_entry_store.sv
module msix_entry_store
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        wr_en,
    input  logic [((NUM_VEC > 1) ? $clog2(NUM_VEC) : 1)-1:0] wr_idx,
    input  word_sel_e                                   wr_word,
    input  logic [31:0]                                 wr_data,
    input  logic [((NUM_VEC > 1) ? $clog2(NUM_VEC) : 1)-1:0] rd_idx,
    input  word_sel_e                                   rd_word,
    output logic [31:0]                                 rd_data,
    input  logic [((NUM_VEC > 1) ? $clog2(NUM_VEC) : 1)-1:0] msg_idx,
    output logic [63:0]                                 msg_addr,
    output logic [31:0]                                 msg_data,
    output logic [NUM_VEC-1:0]                          mask_vec
);

    logic [NUM_VEC-1:0][31:0] lo_d, lo_q;
    logic [NUM_VEC-1:0][31:0] hi_d, hi_q;
    logic [NUM_VEC-1:0][31:0] dat_d, dat_q;
    logic [NUM_VEC-1:0]       msk_d, msk_q;

    always_comb begin
        lo_d  = lo_q;
        hi_d  = hi_q;
        dat_d = dat_q;
        msk_d = msk_q;
        if (wr_en) begin
            case (wr_word)
                W_ADDR_LO: lo_d[wr_idx]  = wr_data;
                W_ADDR_HI: hi_d[wr_idx]  = wr_data;
                W_DATA:    dat_d[wr_idx] = wr_data;
                default:   msk_d[wr_idx] = wr_data[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            dat_q <= '0;
            msk_q <= '1;
        end else begin
            lo_q  <= lo_d;
            hi_q  <= hi_d;
            dat_q <= dat_d;
            msk_q <= msk_d;
        end
    end

    always_comb begin
        case (rd_word)
            W_ADDR_LO: rd_data = lo_q[rd_idx];
            W_ADDR_HI: rd_data = hi_q[rd_idx];
            W_DATA:    rd_data = dat_q[rd_idx];
            default:   rd_data = {31'd0, msk_q[rd_idx]};
        endcase
    end

    assign msg_addr = {hi_q[msg_idx], lo_q[msg_idx]};
    assign msg_data = dat_q[msg_idx];
    assign mask_vec = msk_q;

endmodule

// File: rtl/msix_use_ctr.sv
module msix_use_ctr #(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        inc_hit,
    input  logic                                        dec_hit,
    input  logic [((NUM_VEC > 1) ? $clog2(NUM_VEC) : 1)-1:0] cmd_idx,
    output logic [NUM_VEC-1:0]                          in_use,
    output logic                                        hit_zero
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [NUM_VEC-1:0][CNT_W-1:0] cnt_d, cnt_q;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_cnt
        logic sel;
        assign sel = (int'(cmd_idx) == v);

        always_comb begin
            cnt_d[v] = cnt_q[v];
            if (sel && inc_hit && !dec_hit && cnt_q[v] != CNT_MAX)
                cnt_d[v] = cnt_q[v] + CNT_ONE;
            else if (sel && dec_hit && !inc_hit && cnt_q[v] != '0)
                cnt_d[v] = cnt_q[v] - CNT_ONE;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q[v] <= '0;
            else        cnt_q[v] <= cnt_d[v];
        end

        assign in_use[v] = (cnt_q[v] != '0);
    end

    // a decrement from one brings the count to zero in this cycle
    assign hit_zero = dec_hit && !inc_hit && (cnt_q[cmd_idx] == CNT_ONE);

endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [11:0] reg_addr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ctl_wr,
    input  logic        ctl_en,
    input  logic        ctl_maskall,
    input  logic        irq_req,
    input  logic [4:0]  irq_vec,
    output logic        busy,
    input  logic        use_cmd,
    input  logic        unuse_cmd,
    input  logic [4:0]  cmd_vec,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data,
    output logic        intx_deassert
);

    localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VEC - 1);

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic               en;
        logic               fmask;
        logic               scan_on;
        logic [IDX_W-1:0]   scan_idx;
        logic               mval;
        logic [IDX_W-1:0]   mvec;
        logic               intx;
    } core_t;

    core_t st_d, st_q;

    // register window decode
    logic             full_acc;
    logic             tbl_region;
    logic             ent_in_rng;
    logic [IDX_W-1:0] ent_idx;
    word_sel_e        ent_word;
    logic             tbl_wr_hit;
    logic [31:0]      store_rd;
    logic [NUM_VEC-1:0] mask_vec;
    logic             mask_post;

    assign full_acc   = (reg_be == 4'hF);
    assign tbl_region = !reg_addr[11];
    assign ent_in_rng = (int'(reg_addr[10:4]) < NUM_VEC);
    assign ent_idx    = reg_addr[4 +: IDX_W];
    assign ent_word   = word_sel_e'(reg_addr[3:2]);
    assign tbl_wr_hit = reg_wr && full_acc && tbl_region && ent_in_rng;

    // request and command decode
    logic             irq_in_rng, cmd_in_rng;
    logic [IDX_W-1:0] irq_idx, cmd_idx;
    logic [NUM_VEC-1:0] in_use;
    logic             hit_zero;
    logic             irq_hit;
    logic             slot_free;

    assign irq_in_rng = (int'(irq_vec) < NUM_VEC);
    assign cmd_in_rng = (int'(cmd_vec) < NUM_VEC);
    assign irq_idx    = irq_vec[IDX_W-1:0];
    assign cmd_idx    = cmd_vec[IDX_W-1:0];
    assign irq_hit    = irq_req && irq_in_rng && in_use[irq_idx];
    assign slot_free  = !st_q.mval || msg_ready;

    msix_entry_store #(.NUM_VEC(NUM_VEC)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_hit),
        .wr_idx   (ent_idx),
        .wr_word  (ent_word),
        .wr_data  (reg_wdata),
        .rd_idx   (ent_idx),
        .rd_word  (ent_word),
        .rd_data  (store_rd),
        .msg_idx  (st_q.mvec),
        .msg_addr (msg_addr),
        .msg_data (msg_data),
        .mask_vec (mask_vec)
    );

    msix_use_ctr #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_use (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_hit  (use_cmd && cmd_in_rng),
        .dec_hit  (unuse_cmd && cmd_in_rng),
        .cmd_idx  (cmd_idx),
        .in_use   (in_use),
        .hit_zero (hit_zero)
    );

    // mask of the written entry as it stands after this write
    assign mask_post = (ent_word == W_CTRL) ? reg_wdata[0] : mask_vec[ent_idx];

    always_comb begin
        st_d      = st_q;
        st_d.intx = 1'b0;

        if (st_q.mval && msg_ready)
            st_d.mval = 1'b0;

        // control byte write
        if (ctl_wr) begin
            st_d.en    = ctl_en;
            st_d.fmask = ctl_maskall;
            if (ctl_en) begin
                st_d.intx = 1'b1;
                if (!ctl_maskall) begin
                    st_d.scan_on  = 1'b1;
                    st_d.scan_idx = '0;
                end
            end
        end

        // replay walk, one vector per free output slot
        if (st_q.scan_on && slot_free) begin
            if (!st_q.fmask && !mask_vec[st_q.scan_idx] && st_q.pend[st_q.scan_idx]) begin
                st_d.pend[st_q.scan_idx] = 1'b0;
                st_d.mval                = 1'b1;
                st_d.mvec                = st_q.scan_idx;
            end
            if (st_q.scan_idx == LAST_IDX)
                st_d.scan_on = 1'b0;
            else
                st_d.scan_idx = st_q.scan_idx + IDX_W'(1);
        end

        // table write: recheck the owning vector
        if (tbl_wr_hit && !st_d.fmask && !mask_post && st_d.pend[ent_idx]) begin
            st_d.pend[ent_idx] = 1'b0;
            st_d.mval          = 1'b1;
            st_d.mvec          = ent_idx;
        end

        // device interrupt request
        if (irq_hit) begin
            if (st_q.fmask || mask_vec[irq_idx]) begin
                st_d.pend[irq_idx] = 1'b1;
            end else begin
                st_d.mval = 1'b1;
                st_d.mvec = irq_idx;
            end
        end

        // last user released: forget a parked request
        if (hit_zero)
            st_d.pend[cmd_idx] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read path
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && full_acc) begin
            if (tbl_region) begin
                if (ent_in_rng) reg_rdata = store_rd;
            end else if (reg_addr[10:2] == 9'd0) begin
                reg_rdata = 32'(st_q.pend);
            end
        end
    end

    assign busy          = st_q.scan_on || (st_q.mval && !msg_ready);
    assign msg_valid     = st_q.mval;
    assign intx_deassert = st_q.intx;

endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
    parameter int NUM_VEC = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        ctl_wr,
    input logic        ctl_en,
    input logic        ctl_maskall,
    input logic        irq_req,
    input logic [4:0]  irq_vec,
    input logic        busy,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data,
    input logic        intx_deassert
);

    // R11
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // R5
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msg_valid) |-> $past(msg_ready));

    // R9
    intx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intx_deassert |-> $past(ctl_wr && ctl_en));

    // R9
    scan_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_en && !ctl_maskall |=> busy);

    // R6
    drop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !busy && !reg_wr && !ctl_wr && !msg_valid && (int'(irq_vec) >= NUM_VEC)
        |=> !msg_valid);

endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .ctl_wr        (ctl_wr),
    .ctl_en        (ctl_en),
    .ctl_maskall   (ctl_maskall),
    .irq_req       (irq_req),
    .irq_vec       (irq_vec),
    .busy          (busy),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .msg_addr      (msg_addr),
    .msg_data      (msg_data),
    .intx_deassert (intx_deassert)
);

// File: tb/sim_msix_vec_ctrl.sv
module sim_msix_vec_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [3:0]  reg_be = 4'hF;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_wr = 1'b0, ctl_en = 1'b0, ctl_maskall = 1'b0;
    logic        irq_req = 1'b0;
    logic [4:0]  irq_vec = '0;
    logic        busy;
    logic        use_cmd = 1'b0, unuse_cmd = 1'b0;
    logic [4:0]  cmd_vec = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic        intx_deassert;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    msix_vec_ctrl #(.NUM_VEC(8), .CNT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_maskall(ctl_maskall),
        .irq_req(irq_req), .irq_vec(irq_vec), .busy(busy),
        .use_cmd(use_cmd), .unuse_cmd(unuse_cmd), .cmd_vec(cmd_vec),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data),
        .intx_deassert(intx_deassert)
    );

    localparam logic [31:0] V2_LO = 32'hFEE0_0020, V2_HI = 32'h0000_0001, V2_DT = 32'h0000_00A2;
    localparam logic [31:0] V3_LO = 32'hFEE0_0030, V3_HI = 32'h0000_0000, V3_DT = 32'h0000_00B3;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'hF;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] be, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a; reg_be = be;
        #1 v = reg_rdata;
        reg_rd = 1'b0; reg_be = 4'hF;
    endtask

    task automatic irq(input logic [4:0] v);
        @(negedge clk);
        irq_req = 1'b1; irq_vec = v;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic ctl(input logic en, input logic m);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_en = en; ctl_maskall = m;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic use_v(input logic [4:0] v, input logic dn);
        @(negedge clk);
        use_cmd = !dn; unuse_cmd = dn; cmd_vec = v;
        @(negedge clk);
        use_cmd = 1'b0; unuse_cmd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h00C, 4'hF, v); chk("R1 v0 ctrl", v, 1);
        rd(12'h07C, 4'hF, v); chk("R1 v7 ctrl", v, 1);
        rd(12'h020, 4'hF, v); chk("R1 v2 addr lo", v, 0);
        rd(12'h800, 4'hF, v); chk("R1 pending", v, 0);
        chk("R1 msg_valid", msg_valid, 0);
        chk("R1 busy", busy, 0);
        chk("R1 intx", intx_deassert, 0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        wr(12'h020, V2_LO, 4'hF);
        wr(12'h024, V2_HI, 4'hF);
        wr(12'h028, V2_DT, 4'hF);
        wr(12'h030, V3_LO, 4'hF);
        wr(12'h034, V3_HI, 4'hF);
        wr(12'h038, V3_DT, 4'hF);
        rd(12'h024, 4'hF, v); chk("R2 v2 addr hi", v, V2_HI);
        rd(12'h028, 4'hF, v); chk("R2 v2 data", v, V2_DT);
        rd(12'h030, 4'hF, v); chk("R2 v3 addr lo", v, V3_LO);
        wr(12'h02C, 32'hFFFF_FFFE, 4'hF);
        rd(12'h02C, 4'hF, v); chk("R2 ctrl unmask", v, 0);
        wr(12'h02C, 32'hFFFF_FFFF, 4'hF);
        rd(12'h02C, 4'hF, v); chk("R2 ctrl mask only bit0", v, 1);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        wr(12'h028, 32'h1234_5678, 4'h3);
        rd(12'h028, 4'hF, v); chk("R3 narrow write ignored", v, V2_DT);
        rd(12'h028, 4'h1, v); chk("R3 narrow read zero", v, 0);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        irq(5'd2);
        rd(12'h800, 4'hF, v); chk("R6 unused vector no pending", v, 0);
        chk("R6 unused vector no msg", msg_valid, 0);
        irq(5'd9);
        chk("R6 out of range no msg", msg_valid, 0);
    endtask

    task automatic t_send();
        use_v(5'd2, 1'b0);
        wr(12'h02C, 32'h0, 4'hF);
        chk("R8 unmask without pending no msg", msg_valid, 0);
        msg_ready = 1'b0;
        irq(5'd2);
        chk("R5 msg valid", msg_valid, 1);
        chk("R5 msg addr", msg_addr, {V2_HI, V2_LO});
        chk("R5 msg data", msg_data, V2_DT);
        @(negedge clk);
        chk("R11 held valid", msg_valid, 1);
        chk("R11 held addr", msg_addr, {V2_HI, V2_LO});
        msg_ready = 1'b1;
        @(negedge clk);
        chk("R11 accepted", msg_valid, 0);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        use_v(5'd3, 1'b0);
        irq(5'd3);
        chk("R7 masked no msg", msg_valid, 0);
        rd(12'h800, 4'hF, v); chk("R7 pending bit3", v, 32'h8);
        wr(12'h800, 32'h0, 4'hF);
        rd(12'h800, 4'hF, v); chk("R4 pending write ignored", v, 32'h8);
        rd(12'h804, 4'hF, v); chk("R4 beyond pending reads zero", v, 0);
        wr(12'h03C, 32'h0, 4'hF);
        chk("R8 replay valid", msg_valid, 1);
        chk("R8 replay addr", msg_addr, {V3_HI, V3_LO});
        chk("R8 replay data", msg_data, V3_DT);
        rd(12'h800, 4'hF, v); chk("R8 pending cleared", v, 0);
        @(negedge clk);
    endtask

    task automatic t_scan();
        logic [31:0] v;
        logic [63:0] seen [4];
        int cnt = 0;
        bit saw_busy = 0;
        ctl(1'b1, 1'b1);
        chk("R9 intx strobe", intx_deassert, 1);
        chk("R9 masked no busy", busy, 0);
        @(negedge clk);
        chk("R9 intx one cycle", intx_deassert, 0);
        irq(5'd3);
        irq(5'd2);
        chk("R7 function mask no msg", msg_valid, 0);
        rd(12'h800, 4'hF, v); chk("R7 function mask pending", v, 32'h0C);
        ctl(1'b1, 1'b0);
        for (int i = 0; i < 14; i++) begin
            if (busy) saw_busy = 1;
            if (msg_valid && cnt < 4) begin
                seen[cnt] = msg_addr;
                cnt++;
            end
            @(negedge clk);
        end
        chk("R9 busy during scan", saw_busy, 1);
        chk("R9 scan message count", cnt, 2);
        chk("R9 scan first v2", seen[0], {V2_HI, V2_LO});
        chk("R9 scan second v3", seen[1], {V3_HI, V3_LO});
        chk("R9 busy after scan", busy, 0);
        rd(12'h800, 4'hF, v); chk("R9 pending after scan", v, 0);
    endtask

    task automatic t_use();
        logic [31:0] v;
        ctl(1'b1, 1'b1);
        irq(5'd3);
        rd(12'h800, 4'hF, v); chk("R10 pending before unuse", v, 32'h8);
        use_v(5'd3, 1'b1);
        rd(12'h800, 4'hF, v); chk("R10 zero count clears pending", v, 0);
        use_v(5'd3, 1'b1);
        use_v(5'd3, 1'b0);
        irq(5'd3);
        rd(12'h800, 4'hF, v); chk("R10 unuse at zero no effect", v, 32'h8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_narrow();
        t_drop();
        t_send();
        t_pending();
        t_scan();
        t_use();
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule